// File: doc/BRIEF.md
# Dual-Mode SPI Bit Clock Generator

This block derives the serial bit clock of an SPI master from the module clock. One control word picks one of two dividers. The linear divider gives a half period of N+1 module cycles. The exponent divider gives a half period of 2^(M-1) module cycles. While the generator runs, the serial clock level toggles at the end of every half period. In the cycle in which the level has just changed, a one-cycle strobe is raised so that the transfer engine can launch or sample data on it.

While the run input is low, the counter stays at zero and the clock output sits at the idle polarity. The divider setting is captured in every idle cycle and held for the whole burst. A new setting therefore only applies to the next burst. Software works out the divider value from the target frequency; this block only applies it.

Top module: `spi_bitclk_div`

## Requirements
- R1: While reset is asserted, `sclk_o` is 0 and `edge_tick_o` is 0.
- R2: After a clock edge at which `run_i` was low, `sclk_o` equals the `cpol_i` value seen at that edge, and `edge_tick_o` is 0.
- R3: When `div_ctrl_i[12]` is 1 (linear mode), the half period is N+1 module cycles, where N is `div_ctrl_i[7:0]`. Bits [11:8] have no effect in this mode.
- R4: When `div_ctrl_i[12]` is 0 (exponent mode), the half period is 2^(M-1) module cycles, where M is `div_ctrl_i[11:8]`. Bits [7:0] have no effect in this mode.
- R5: In exponent mode, M=0 behaves like M=1, giving a half period of one cycle. The fastest setting in either mode is half the module clock.
- R6: `edge_tick_o` is high for one cycle in each cycle in which `sclk_o` has just changed. `sclk_o` never changes without it while running.
- R7: The first tick of a burst comes exactly one half period after the first edge at which `run_i` is high. That tick moves `sclk_o` away from the idle polarity. Later ticks alternate the level.
- R8: The divider setting is captured only at edges where `run_i` is low. A change of `div_ctrl_i` or `cpol_i` during a burst does not alter that burst's timing or levels.
- R9: When `run_i` falls partway through a half period, the next edge returns `sclk_o` to `cpol_i` with no tick. A burst started afterwards counts a full fresh half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High while a burst is in progress |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_ctrl_i | input | 13 | Bit 12 selects the mode; [11:8] is the exponent M; [7:0] is the linear N |
| sclk_o | output | 1 | Serial bit clock level |
| edge_tick_o | output | 1 | One-cycle strobe after each serial clock transition |

## Verification
Two pairs of functions can meet in one cycle. The first pair is capturing the setting and starting the count. The second pair is the end of a half period and the release of `run_i`. The bench changes the control word and the polarity on the first counting cycle of a burst, and then expects the scoreboard's gaps and levels for the old setting. It also releases `run_i` on a cycle in which a toggle is due (half period of one cycle, where every cycle is a toggle) and midway through a longer half period. In both cases it then expects the idle level with no strobe, and a fresh full first gap on the next burst.

// File: rtl/spi_bitclk_pkg.sv
package spi_bitclk_pkg;
  // Meaning of the mode-select bit in the control word
  typedef enum logic {
    MODE_EXP = 1'b0,
    MODE_LIN = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_bitclk_cfg.sv
module spi_bitclk_cfg #(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int HALF_W = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_i,
  input  logic [LIN_W+EXP_W:0]       ctrl_i,
  output logic [HALF_W-1:0]          half_o
);
  import spi_bitclk_pkg::*;
  localparam int CTRL_W = LIN_W + EXP_W + 1;

  // Half period in module cycles for one control word
  function automatic logic [HALF_W-1:0] half_of(input logic [CTRL_W-1:0] c);
    logic [EXP_W-1:0]  m;
    logic [HALF_W-1:0] r;
    if (div_mode_e'(c[CTRL_W-1]) == MODE_LIN) begin
      r = HALF_W'(c[LIN_W-1:0]) + HALF_W'(1);
    end else begin
      m = c[LIN_W +: EXP_W];
      if (m == '0) m = EXP_W'(1);
      r = HALF_W'(1) << (m - EXP_W'(1));
    end
    return r;
  endfunction

  logic [HALF_W-1:0] half_q;
  logic              capture_w;

  assign capture_w = !run_i;
  assign half_o    = half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         half_q <= HALF_W'(1);
    else if (capture_w) half_q <= half_of(ctrl_i);
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(run_i) |-> $stable(half_q));
endmodule

// File: rtl/spi_bitclk_phase.sv
module spi_bitclk_phase #(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              wrap_o,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              tick_q;

  assign wrap_o = run_i && (cnt_q == (half_i - HALF_W'(1)));
  assign tick_o = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap_o;
      if (!run_i || wrap_o) cnt_q <= '0;
      else                  cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  // R3 R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_i);
  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(run_i) |-> (cnt_q == '0) && !tick_q);
endmodule

// File: rtl/spi_bitclk_level.sv
module spi_bitclk_level (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic cpol_i,
  input  logic wrap_i,
  output logic sclk_o
);
  logic sclk_q;

  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sclk_q <= 1'b0;
    else if (!run_i) sclk_q <= cpol_i;
    else if (wrap_i) sclk_q <= ~sclk_q;
  end

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(run_i) |-> sclk_q == $past(cpol_i));
endmodule

// File: rtl/spi_bitclk_div.sv
module spi_bitclk_div #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic                 cpol_i,
  input  logic [LIN_W+EXP_W:0] div_ctrl_i,
  output logic                 sclk_o,
  output logic                 edge_tick_o
);
  localparam int EXP_HW = (1 << EXP_W) - 1;
  localparam int HALF_W = (LIN_W + 1 > EXP_HW) ? LIN_W + 1 : EXP_HW;

  logic [HALF_W-1:0] half_w;
  logic              wrap_w;
  logic              tick_w;
  logic              sclk_w;

  spi_bitclk_cfg #(.LIN_W(LIN_W), .EXP_W(EXP_W), .HALF_W(HALF_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ctrl_i(div_ctrl_i), .half_o(half_w));

  spi_bitclk_phase #(.HALF_W(HALF_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .half_i(half_w),
    .wrap_o(wrap_w), .tick_o(tick_w));

  spi_bitclk_level level_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .cpol_i(cpol_i),
    .wrap_i(wrap_w), .sclk_o(sclk_w));

  assign sclk_o      = sclk_w;
  assign edge_tick_o = tick_w;

  // R6
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && edge_tick_o |-> sclk_o != $past(sclk_o));
  // R6
  still_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(run_i) && !edge_tick_o |-> $stable(sclk_o));
  // R5
  half_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_w != '0);
endmodule

// File: tb/spi_bitclk_div_tb_top.sv
module spi_bitclk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic        cpol_i = 1'b0;
  logic [12:0] div_ctrl_i = '0;
  logic        sclk_o;
  logic        edge_tick_o;

  always #4 clk = ~clk;

  spi_bitclk_div dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .cpol_i(cpol_i),
    .div_ctrl_i(div_ctrl_i), .sclk_o(sclk_o), .edge_tick_o(edge_tick_o));

  typedef struct {
    int    gap;
    logic  lvl;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   since = 0;
  bit   done  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Half period restated from R3, R4, R5
  function automatic int half_cycles(input logic [12:0] c);
    int m;
    if (c[12]) return int'(c[7:0]) + 1;
    m = int'(c[11:8]);
    if (m < 1) m = 1;
    return 2 ** (m - 1);
  endfunction

  // Monitor: compares every tick with the scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (run_i) begin
        since++;
        if (edge_tick_o) begin
          if (exp_q.size() == 0) begin
            check(0, "R6 unexpected tick", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(since == e.gap, {e.tag, " gap"}, since, e.gap);
            check(sclk_o == e.lvl, {e.tag, " R7 level"}, int'(sclk_o), int'(e.lvl));
          end
          since = 0;
        end
      end else begin
        since = 0;
        check(sclk_o == cpol_i && !edge_tick_o, "R2 idle level", int'(sclk_o), int'(cpol_i));
      end
    end
  end

  // Driver: settles the setting while idle, queues expectations, runs the burst
  task automatic burst(input logic [12:0] ctrl, input logic pol, input int n,
                       input string tag, input bit change_mid);
    int h;
    @(negedge clk);
    run_i = 1'b0;
    div_ctrl_i = ctrl;
    cpol_i = pol;
    @(negedge clk);
    h = half_cycles(ctrl);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.gap = h;
      e.lvl = (k % 2 == 0) ? ~pol : pol;
      e.tag = tag;
      exp_q.push_back(e);
    end
    run_i = 1'b1;
    if (change_mid) begin
      @(negedge clk);
      div_ctrl_i = {1'b1, 4'h0, 8'd40};
      cpol_i = ~pol;
    end
    while (exp_q.size() != 0) @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(sclk_o == 1'b0, "R1 reset sclk", int'(sclk_o), 0);
    check(edge_tick_o == 1'b0, "R1 reset tick", int'(edge_tick_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    burst({1'b1, 4'hF, 8'd0},  1'b0, 6, "R3 lin N=0 R5", 0);
    burst({1'b1, 4'h0, 8'd3},  1'b1, 4, "R3 lin N=3", 0);
    burst({1'b1, 4'hA, 8'd255}, 1'b0, 3, "R3 lin N=255", 0);
    burst({1'b0, 4'h0, 8'hFF}, 1'b1, 5, "R5 exp M=0", 0);
    burst({1'b0, 4'h1, 8'h00}, 1'b0, 4, "R4 exp M=1", 0);
    burst({1'b0, 4'h4, 8'h5A}, 1'b1, 4, "R4 exp M=4", 0);
    burst({1'b0, 4'hF, 8'h00}, 1'b0, 2, "R4 exp M=15", 0);
    burst({1'b1, 4'h0, 8'd5},  1'b0, 4, "R8 mid change", 1);
    burst({1'b1, 4'h0, 8'd40}, 1'b1, 2, "R8 next burst", 0);

    // R9: release run partway through a half period, then restart
    begin
      exp_t e;
      @(negedge clk);
      div_ctrl_i = {1'b1, 4'h0, 8'd7};
      cpol_i = 1'b1;
      @(negedge clk);
      e.gap = 8; e.lvl = 1'b0; e.tag = "R9 first";
      exp_q.push_back(e);
      run_i = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      run_i = 1'b0;
      @(posedge clk);
      #3;
      check(sclk_o == 1'b1, "R9 abort level", int'(sclk_o), 1);
      check(edge_tick_o == 1'b0, "R9 abort tick", int'(edge_tick_o), 0);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        e.gap = 8; e.lvl = (k == 0) ? 1'b0 : 1'b1; e.tag = "R9 restart";
        exp_q.push_back(e);
      end
      run_i = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);
      run_i = 1'b0;
      @(negedge clk);
    end

    // R2/R6: run released on the cycle a toggle is due (half period 1)
    burst({1'b0, 4'h0, 8'h00}, 1'b1, 1, "R6 drop on due toggle", 0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 leftover", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule